// File: doc/BRIEF.md
# Fourth-Order Sinc Decimator with Two Output Rates

This block turns a one-bit delta-sigma modulator stream, one bit per clock, into 20-bit two's-complement conversion words. It uses a cascade of four integrators running at the input rate and four comb stages running at the output rate. A static rate input picks between a slow decimation ratio and a fast ratio that is one eighth of it. Each input bit counts as +1 when high and −1 when low. The comb result is rescaled so that a stream of all ones maps to positive full scale and a stream of all zeros maps to negative full scale. The result then saturates at the 20-bit signed limits instead of wrapping.

A restart input, or any change on the rate input, clears the whole filter. The four-stage filter needs four output periods of fresh input before its window is free of stale history. For that reason the block emits no word and keeps its settled flag low until the fourth word after the clear. From then on it strobes a one-cycle valid for every word, and the flag stays high until the next clear.

Top module: `sinc4_decim`

## Requirements
- R1: While reset is held and after it is released, `word` is 0, `word_valid` is 0 and `settled` is 0 until the first settled word.
- R2: Once settled, successive `word_valid` strobes are exactly R_SLOW cycles apart when `rate_sel` is 0 and exactly R_SLOW/8 cycles apart when `rate_sel` is 1.
- R3: After the clock edge that captures a restart, the first `word_valid` appears exactly 4·R clock edges later, where R is the ratio of the selected rate. No strobe appears before that.
- R4: `settled` rises in the same cycle as the first `word_valid` after a clear and stays high while no clear occurs. `word_valid` is never high while `settled` is low.
- R5: A high `restart` clears the filter. In the next cycle `settled` and `word_valid` are 0, and the next word depends only on input bits taken after the clear.
- R6: A change on `rate_sel` without `restart` has the same clearing effect as a restart, and the filter then runs at the new ratio.
- R7: Input bit 1 counts as +1 and bit 0 as −1. For an input pattern of period 8 with m ones per period (0 < m < 8), the settled word equals (2m−8)·2^16 in 20-bit two's complement. An even mix of ones and zeros gives 20'h00000.
- R8: An all-ones input gives 20'h7FFFF, which is clipped from +2^19. An all-zeros input gives 20'h80000.
- R9: `word_valid` lasts one cycle, and `word` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one modulator bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear of filter and settling state |
| rate_sel | input | 1 | 0 = slow ratio R_SLOW, 1 = fast ratio R_SLOW/8 |
| mod_bit | input | 1 | Modulator output bit |
| word | output | 20 | Latest settled conversion word, two's complement |
| word_valid | output | 1 | One-cycle strobe for a new word |
| settled | output | 1 | High from the fourth word after a clear |

## Verification
The assertions assume that `rate_sel` changes only at clock edges and that `restart` is a clean synchronous level. Under these assumptions, comparing `rate_sel` with its previous value detects a rate change exactly as the block does. The stimulus changes `rate_sel`, `restart` and `mod_bit` only on falling edges. It holds each periodic pattern over whole windows, so every expected word follows from the duty cycle alone. The bench sweeps every duty of an eight-bit period at both rates, and each sweep step begins with a restart.

// File: rtl/sinc4_pkg.sv
`timescale 1ns/1ps
package sinc4_pkg;
    localparam int ORDER = 4;
    localparam int OUT_W = 20;
    localparam int FAST_DIV = 8;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;
endpackage

// File: rtl/sinc4_integ.sv
`timescale 1ns/1ps
module sinc4_integ
    import sinc4_pkg::*;
#(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_in,
    output logic [W-1:0] acc_out
);
    typedef struct packed {
        logic [ORDER-1:0][W-1:0] acc;
    } integ_t;

    integ_t st_d, st_q;
    logic [W-1:0] x;
    logic [W-1:0] run;

    assign x = bit_in ? W'(1) : '1;

    always_comb begin
        st_d = st_q;
        run  = x;
        for (int i = 0; i < ORDER; i++) begin
            st_d.acc[i] = st_q.acc[i] + run;
            run         = st_d.acc[i];
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_out = st_q.acc[ORDER-1];
endmodule

// File: rtl/sinc4_comb.sv
`timescale 1ns/1ps
module sinc4_comb
    import sinc4_pkg::*;
#(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] diff
);
    typedef struct packed {
        logic [ORDER-1:0][W-1:0] dly;
    } comb_t;

    comb_t st_d, st_q;
    logic [W-1:0] run;

    always_comb begin
        st_d = st_q;
        run  = din;
        for (int i = 0; i < ORDER; i++) begin
            if (tick) st_d.dly[i] = run;
            run = run - st_q.dly[i];
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign diff = run;
endmodule

// File: rtl/sinc4_scale.sv
`timescale 1ns/1ps
module sinc4_scale
    import sinc4_pkg::*;
#(
    parameter int W     = 26,
    parameter int SHIFT = 5
) (
    input  logic [W-1:0]     din,
    output logic [OUT_W-1:0] code
);
    localparam int SW = W + 24;
    localparam logic signed [SW-1:0] HI = SW'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SW-1:0] LO = -HI - SW'(1);

    logic signed [SW-1:0] ext;
    logic signed [SW-1:0] sc;

    assign ext = {{(SW - W){din[W-1]}}, din};

    generate
        if (SHIFT >= 0) begin : g_down
            assign sc = ext >>> SHIFT;
        end else begin : g_up
            assign sc = ext <<< (-SHIFT);
        end
    endgenerate

    always_comb begin
        if (sc > HI)      code = {1'b0, {(OUT_W-1){1'b1}}};
        else if (sc < LO) code = {1'b1, {(OUT_W-1){1'b0}}};
        else              code = sc[OUT_W-1:0];
    end
endmodule

// File: rtl/sinc4_decim.sv
`timescale 1ns/1ps
module sinc4_decim
    import sinc4_pkg::*;
#(
    parameter int R_SLOW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             rate_sel,
    input  logic             mod_bit,
    output logic [OUT_W-1:0] word,
    output logic             word_valid,
    output logic             settled
);
    localparam int R_FAST = R_SLOW / FAST_DIV;
    localparam int LOG_S  = $clog2(R_SLOW);
    localparam int LOG_F  = $clog2(R_FAST);
    localparam int W      = ORDER * LOG_S + 2;
    localparam int CW     = LOG_S;
    localparam int SH_S   = ORDER * LOG_S - (OUT_W - 1);
    localparam int SH_F   = ORDER * LOG_F - (OUT_W - 1);
    localparam logic [CW-1:0] LAST_S = CW'(R_SLOW - 1);
    localparam logic [CW-1:0] LAST_F = CW'(R_FAST - 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        rate_e            rate;
        logic [1:0]       words;
        logic [OUT_W-1:0] data;
        logic             valid;
        logic             settled;
    } ctl_t;

    ctl_t st_d, st_q;
    logic clr, tick;
    logic [W-1:0] integ_out, comb_out;
    logic [OUT_W-1:0] code_s, code_f;

    assign clr  = restart || (rate_e'(rate_sel) != st_q.rate);
    assign tick = !clr && (st_q.cnt == ((st_q.rate == RATE_FAST) ? LAST_F : LAST_S));

    sinc4_integ #(.W(W)) i_integ (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_in(mod_bit), .acc_out(integ_out)
    );

    sinc4_comb #(.W(W)) i_comb (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .din(integ_out), .diff(comb_out)
    );

    sinc4_scale #(.W(W), .SHIFT(SH_S)) i_scale_slow (.din(comb_out), .code(code_s));
    sinc4_scale #(.W(W), .SHIFT(SH_F)) i_scale_fast (.din(comb_out), .code(code_f));

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.rate  = rate_e'(rate_sel);
        if (clr) begin
            st_d.cnt     = '0;
            st_d.words   = '0;
            st_d.settled = 1'b0;
        end else if (tick) begin
            st_d.cnt = '0;
            if (st_q.words == 2'd3) begin
                st_d.valid   = 1'b1;
                st_d.settled = 1'b1;
                st_d.data    = (st_q.rate == RATE_FAST) ? code_f : code_s;
            end else begin
                st_d.words = st_q.words + 2'd1;
            end
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, rate: RATE_SLOW, words: '0, data: '0, valid: 1'b0, settled: 1'b0};
        else        st_q <= st_d;
    end

    assign word       = st_q.data;
    assign word_valid = st_q.valid;
    assign settled    = st_q.settled;
endmodule

// File: rtl/sinc4_decim_chk.sv
`timescale 1ns/1ps
module sinc4_decim_chk
    import sinc4_pkg::*;
#(
    parameter int R_SLOW = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             rate_sel,
    input logic [OUT_W-1:0] word,
    input logic             word_valid,
    input logic             settled
);
    localparam int R_FAST = R_SLOW / FAST_DIV;
    localparam int SAT    = 4 * R_SLOW + 8;

    logic sel_prev, seen;
    int   since, gap;
    int   ratio;

    assign ratio = rate_sel ? R_FAST : R_SLOW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_prev <= 1'b0;
            seen     <= 1'b0;
            since    <= 0;
            gap      <= 0;
        end else begin
            sel_prev <= rate_sel;
            if (restart || rate_sel != sel_prev) begin
                seen  <= 1'b0;
                since <= 0;
            end else begin
                if (since < SAT) since <= since + 1;
                if (word_valid) seen <= 1'b1;
            end
            if (word_valid) gap <= 1;
            else if (gap < SAT) gap <= gap + 1;
        end
    end

    a_r2_word_interval: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && seen) |-> (gap == ratio));
    a_r3_first_word_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !seen) |-> (since == 4 * ratio));
    a_r4_valid_needs_settled: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> settled);
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!settled && !word_valid));
    a_r6_rate_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != $past(rate_sel)) |=> !settled);
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    a_r9_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word));
endmodule

bind sinc4_decim sinc4_decim_chk #(.R_SLOW(R_SLOW)) i_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .rate_sel(rate_sel),
    .word(word), .word_valid(word_valid), .settled(settled)
);

// File: tb/test_sinc4_decim.sv
`timescale 1ns/1ps
module test_sinc4_decim;
    localparam int RS = 64;
    localparam int RF = RS / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        rate_sel = 1'b0;
    logic        mod_bit = 1'b0;
    logic [19:0] word;
    logic        word_valid;
    logic        settled;

    int errors = 0;
    int checks = 0;
    int pat_m  = 4;
    logic pat_run = 1'b0;

    always #5 clk = ~clk;

    sinc4_decim #(.R_SLOW(RS)) i_sinc4_decim (
        .clk(clk), .rst_n(rst_n), .restart(restart), .rate_sel(rate_sel),
        .mod_bit(mod_bit), .word(word), .word_valid(word_valid), .settled(settled)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_code(input int m);
        int v;
        v = (2 * m - 8) * 65536;
        if (v > 524287) return 20'h7FFFF;
        return v[19:0];
    endfunction

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!word_valid && n < 8 * RS);
    endtask

    task automatic start(input logic sel);
        @(negedge clk);
        rate_sel = sel;
        restart  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
        chk(!settled && !word_valid, "R5 cleared after restart", {settled, word_valid}, 0);
    endtask

    task automatic run_case(input logic sel, input int m);
        int n, r;
        logic [19:0] d;
        string rq;
        r  = sel ? RF : RS;
        rq = (m == 0 || m == 8) ? "R8 saturation" : "R7 duty code";
        pat_m = m;
        start(sel);
        wait_valid(n);
        chk(n == 4 * r, "R3 first word latency", n, 4 * r);
        chk(settled, "R4 settled with first word", settled, 1);
        chk(word == exp_code(m), rq, word, exp_code(m));
        d = word;
        @(posedge clk); @(negedge clk);
        chk(!word_valid && word == d, "R9 one-cycle strobe and hold", {word_valid, word}, {1'b0, d});
        wait_valid(n);
        chk(n == r - 1, "R2 word interval", n + 1, r);
        chk(word == exp_code(m) && settled, rq, word, exp_code(m));
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (pat_run) begin
                for (int k = 0; k < 8; k++) begin
                    mod_bit = (k < pat_m);
                    if (k < 7) @(negedge clk);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(word == 0 && !word_valid && !settled, "R1 reset state", {word, word_valid, settled}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(word == 0 && !word_valid && !settled, "R1 after release", {word, word_valid, settled}, 0);
        pat_run = 1'b1;
        for (int s = 0; s < 2; s++)
            for (int m = 0; m <= 8; m++)
                run_case(s[0], m);
        run_case(1'b0, 5);
        @(negedge clk);
        rate_sel = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!settled && !word_valid, "R6 rate change clears", settled, 0);
        wait_valid(n);
        chk(n == 4 * RF, "R6 latency at new rate", n, 4 * RF);
        chk(word == exp_code(5), "R6 value at new rate", word, exp_code(5));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule